// File: doc/BRIEF.md
# Grouped Interrupt Distributor

This block gathers level-sensitive interrupt requests from peripherals, holds a security group, an enable and an 8-bit priority for every interrupt number, and tells one processor interface which pending interrupt should be taken. Peripheral request line k is known inside the block as interrupt number k+32. Numbers 0 to 31 are reserved for processor-private sources and have no request input in this instance.

Each interrupt number belongs to group 0 or group 1. A global control word switches forwarding on or off for each group. A second control bit decides whether a winning group 0 interrupt is raised on the fast-interrupt output or on the normal-interrupt output. A group 1 winner always goes to the normal output. Among the forwarded candidates, the one with the numerically lowest priority value wins, and equal priorities go to the lower number.

Software reaches the state through a 32-bit word-addressed register bus. The bus has a combinational read path and a write strobe that takes effect on the clock edge.

Top module: `gd_distrib`

## Requirements
- R1: After synchronous reset, every group bit, enable bit and priority field is 0, the control word is 0, every register reads 0, and no output is raised whatever the request lines do.
- R2: The group bank starts at word address 0x020. Interrupt n lives in word 0x020+n/32, bit n%32. A bit value of 0 selects group 0 and 1 selects group 1. The bank reads back what was written.
- R3: The set-enable bank starts at word address 0x040 (word n/32, bit n%32). Writing 1 to a bit sets that enable, and writing 0 leaves it unchanged. A read returns the current enables.
- R4: The clear-enable bank starts at word address 0x060 with the same layout. Writing 1 to a bit clears that enable, and writing 0 leaves it unchanged. A read returns the current enables.
- R5: Priorities start at word address 0x100. Interrupt n uses word 0x100+n/4, bits [8*(n%4)+7 : 8*(n%4)]. They are read/write.
- R6: The control word is at address 0x000. Bit 0 forwards group 0, bit 1 forwards group 1, and bit 3 routes group 0 winners to the fast output. All other bits read 0.
- R7: The candidates are the interrupts whose line is high, whose enable is set and whose group is forwarded. The winner is the candidate with the lowest priority value, and ties go to the lowest number. hp_valid_o and hp_id_o report the winner.
- R8: A group 0 winner raises fast_irq_o when bit 3 is set and norm_irq_o otherwise. A group 1 winner raises norm_irq_o. At most one output is high at a time, and both are low when there is no winner.
- R9: Peripheral line k drives interrupt number k+32. Numbers below 32 never become candidates, even when they are enabled.
- R10: Reads of word addresses outside the implemented registers return 0, and writes to them change nothing.
- R11: The outputs follow the request lines within the same cycle. A register write changes the outputs only from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 10 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| periph_irq_i | input | NUM_IRQ-32 | Level request lines; bit k is interrupt number k+32 |
| fast_irq_o | output | 1 | Fast-interrupt request |
| norm_irq_o | output | 1 | Normal-interrupt request |
| hp_valid_o | output | 1 | A winner exists |
| hp_id_o | output | $clog2(NUM_IRQ) | Number of the winner |

## Verification
Two events can fall in the same cycle: a clear-enable write that removes one candidate, and a request line that drops for a different candidate. The bench provokes this by lowering the line of the current winner while the clear-enable write for the runner-up is held on the bus. It then checks that before the capturing edge the runner-up already wins, because the line path is combinational. It also checks that after the edge no winner is left.

// File: rtl/gd_pkg.sv
package gd_pkg;

    localparam int ADDR_W   = 10;
    localparam int PRIO_W   = 8;
    localparam int SPI_BASE = 32;

    localparam logic [4:0] GRP_PAGE   = 5'd1;
    localparam logic [4:0] SETEN_PAGE = 5'd2;
    localparam logic [4:0] CLREN_PAGE = 5'd3;
    localparam logic [1:0] PRIO_PAGE  = 2'b01;

    typedef enum logic [2:0] {
        RK_NONE, RK_CTRL, RK_GRP, RK_SETEN, RK_CLREN, RK_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic fast_sel;
        logic grp1_en;
        logic grp0_en;
    } ctrl_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a,
                                        input int unsigned bank_words,
                                        input int unsigned prio_words);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = '0;
        if (a == '0) begin
            s.kind = RK_CTRL;
        end else if (a[9:8] == PRIO_PAGE) begin
            if (32'(a[7:0]) < prio_words) begin
                s.kind = RK_PRIO;
                s.idx  = a[7:0];
            end
        end else if (32'(a[4:0]) < bank_words) begin
            s.idx = {3'b000, a[4:0]};
            case (a[9:5])
                GRP_PAGE:   s.kind = RK_GRP;
                SETEN_PAGE: s.kind = RK_SETEN;
                CLREN_PAGE: s.kind = RK_CLREN;
                default:    s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        return {28'd0, c.fast_sel, 1'b0, c.grp1_en, c.grp0_en};
    endfunction

endpackage

// File: rtl/gd_regfile.sv
module gd_regfile
    import gd_pkg::*;
#(
    parameter int NUM_IRQ = 256
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic                             wr_i,
    input  logic [31:0]                      wdata_i,
    output logic [31:0]                      rdata_o,
    output ctrl_t                            ctrl_o,
    output logic [NUM_IRQ-1:0]               grp_o,
    output logic [NUM_IRQ-1:0]               en_o,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_o
);
    localparam int BANK_WORDS = NUM_IRQ / 32;
    localparam int PRIO_WORDS = NUM_IRQ / 4;

    reg_sel_t sel;
    assign sel = decode(addr_i, BANK_WORDS, PRIO_WORDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            grp_o  <= '0;
            en_o   <= '0;
            prio_o <= '0;
        end else if (wr_i) begin
            case (sel.kind)
                RK_CTRL: begin
                    ctrl_o.fast_sel <= wdata_i[3];
                    ctrl_o.grp1_en  <= wdata_i[1];
                    ctrl_o.grp0_en  <= wdata_i[0];
                end
                RK_GRP: begin
                    for (int w = 0; w < BANK_WORDS; w++)
                        if (8'(w) == sel.idx) grp_o[w*32 +: 32] <= wdata_i;
                end
                RK_SETEN: begin
                    for (int w = 0; w < BANK_WORDS; w++)
                        if (8'(w) == sel.idx)
                            for (int b = 0; b < 32; b++)
                                if (wdata_i[b]) en_o[w*32+b] <= 1'b1;
                end
                RK_CLREN: begin
                    for (int w = 0; w < BANK_WORDS; w++)
                        if (8'(w) == sel.idx)
                            for (int b = 0; b < 32; b++)
                                if (wdata_i[b]) en_o[w*32+b] <= 1'b0;
                end
                RK_PRIO: begin
                    for (int w = 0; w < PRIO_WORDS; w++)
                        if (8'(w) == sel.idx) prio_o[w*4 +: 4] <= wdata_i;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel.kind)
            RK_CTRL: rdata_o = ctrl_word(ctrl_o);
            RK_GRP: begin
                for (int w = 0; w < BANK_WORDS; w++)
                    if (8'(w) == sel.idx) rdata_o = grp_o[w*32 +: 32];
            end
            RK_SETEN, RK_CLREN: begin
                for (int w = 0; w < BANK_WORDS; w++)
                    if (8'(w) == sel.idx) rdata_o = en_o[w*32 +: 32];
            end
            RK_PRIO: begin
                for (int w = 0; w < PRIO_WORDS; w++)
                    if (8'(w) == sel.idx) rdata_o = prio_o[w*4 +: 4];
            end
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/gd_pend_gate.sv
module gd_pend_gate
    import gd_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    parameter int NUM_SPI = NUM_IRQ - SPI_BASE
) (
    input  logic [NUM_SPI-1:0] lines_i,
    input  logic [NUM_IRQ-1:0] grp_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  ctrl_t              ctrl_i,
    output logic [NUM_IRQ-1:0] pend_o
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
        if (i < SPI_BASE) begin : g_private
            assign pend_o[i] = 1'b0;
        end else begin : g_shared
            logic fwd;
            assign fwd       = grp_i[i] ? ctrl_i.grp1_en : ctrl_i.grp0_en;
            assign pend_o[i] = lines_i[i-SPI_BASE] & en_i[i] & fwd;
        end
    end
endmodule

// File: rtl/gd_prio_select.sv
module gd_prio_select
    import gd_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    parameter int ID_W    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]             pend_i,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
    output logic                           valid_o,
    output logic [ID_W-1:0]                id_o
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        best    = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend_i[i] && (!valid_o || prio_i[i] < best)) begin
                valid_o = 1'b1;
                id_o    = ID_W'(i);
                best    = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/gd_distrib.sv
module gd_distrib
    import gd_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    parameter int ID_W    = $clog2(NUM_IRQ),
    parameter int NUM_SPI = NUM_IRQ - SPI_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic [NUM_SPI-1:0]  periph_irq_i,
    output logic                fast_irq_o,
    output logic                norm_irq_o,
    output logic                hp_valid_o,
    output logic [ID_W-1:0]     hp_id_o
);
    ctrl_t                          ctrl_q;
    logic [NUM_IRQ-1:0]             grp_q;
    logic [NUM_IRQ-1:0]             en_q;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_IRQ-1:0]             pend;
    logic                           win_grp1;

    gd_regfile #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .ctrl_o  (ctrl_q),
        .grp_o   (grp_q),
        .en_o    (en_q),
        .prio_o  (prio_q)
    );

    gd_pend_gate #(.NUM_IRQ(NUM_IRQ), .NUM_SPI(NUM_SPI)) u_gate (
        .lines_i (periph_irq_i),
        .grp_i   (grp_q),
        .en_i    (en_q),
        .ctrl_i  (ctrl_q),
        .pend_o  (pend)
    );

    gd_prio_select #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_sel (
        .pend_i  (pend),
        .prio_i  (prio_q),
        .valid_o (hp_valid_o),
        .id_o    (hp_id_o)
    );

    assign win_grp1   = grp_q[hp_id_o];
    assign fast_irq_o = hp_valid_o && !win_grp1 && ctrl_q.fast_sel;
    assign norm_irq_o = hp_valid_o && !(!win_grp1 && ctrl_q.fast_sel);

endmodule

// File: rtl/gd_distrib_chk.sv
module gd_distrib_chk
    import gd_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    parameter int ID_W    = $clog2(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               bus_wr_i,
    input logic [31:0]        bus_wdata_i,
    input logic               fast_irq_o,
    input logic               norm_irq_o,
    input logic               hp_valid_o,
    input logic [ID_W-1:0]    hp_id_o,
    input logic [NUM_IRQ-1:0] en_q,
    input ctrl_t              ctrl_q
);
    // R8: never both outputs
    a_r8_one_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fast_irq_o, norm_irq_o}));

    // R8: fast output needs fast routing and group 0 forwarding
    a_r8_fast_gate: assert property (@(posedge clk) disable iff (rst)
        fast_irq_o |-> (ctrl_q.fast_sel && ctrl_q.grp0_en));

    // R9: a winner is a shared number whose enable is set
    a_r9_winner_shared: assert property (@(posedge clk) disable iff (rst)
        hp_valid_o |-> (32'(hp_id_o) >= SPI_BASE && en_q[hp_id_o]));

    // R6: no forwarding, no winner
    a_r6_ctrl_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.grp0_en && !ctrl_q.grp1_en) |-> !hp_valid_o);

    // R4: all-ones clear of word 0 empties it
    a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == 10'h060 && bus_wdata_i == 32'hFFFF_FFFF)
        |=> (en_q[31:0] == 32'd0));

    // R1: state is clear on the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && ctrl_q == '0 && !hp_valid_o));
endmodule

bind gd_distrib gd_distrib_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .fast_irq_o  (fast_irq_o),
    .norm_irq_o  (norm_irq_o),
    .hp_valid_o  (hp_valid_o),
    .hp_id_o     (hp_id_o),
    .en_q        (en_q),
    .ctrl_q      (ctrl_q)
);

// File: tb/gd_distrib_bench.sv
`timescale 1ns/1ps
module gd_distrib_bench;
    localparam int N    = 64;
    localparam int IDW  = $clog2(N);
    localparam int NSPI = N - 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [9:0]      addr = '0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NSPI-1:0] periph = '0;
    logic            fast, norm, hpv;
    logic [IDW-1:0]  hpid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gd_distrib #(.NUM_IRQ(N)) u_gd_distrib (
        .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .periph_irq_i(periph),
        .fast_irq_o(fast), .norm_irq_o(norm), .hp_valid_o(hpv), .hp_id_o(hpid)
    );

    function automatic logic [7:0] pv(input int id);
        return 8'(8'hC0 - id);
    endfunction

    task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
        addr = a; wr = 1'b0;
        #1;
        n_chk++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic out_chk(input logic ev, input int eid, input logic ef, input logic en,
                           input string tag);
        #1;
        n_chk++;
        if (hpv !== ev || (ev && 32'(hpid) != eid) || fast !== ef || norm !== en) begin
            n_fail++;
            $display("FAIL %s actual v=%0b id=%0d f=%0b n=%0b expected v=%0b id=%0d f=%0b n=%0b",
                     tag, hpv, hpid, fast, norm, ev, eid, ef, en);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(10'h000, 0, "R1 ctrl");
        for (int w = 0; w < 2; w++) begin
            rd_chk(10'(32'h020 + w), 0, "R1 grp");
            rd_chk(10'(32'h040 + w), 0, "R1 en");
        end
        for (int w = 0; w < 16; w++) rd_chk(10'(32'h100 + w), 0, "R1 prio");
        periph = '1;
        out_chk(0, 0, 0, 0, "R1 outputs idle");
        periph = '0;

        // R2 group bank
        wr_reg(10'h020, 32'hA5A5_5A5A);
        wr_reg(10'h021, 32'h1234_5678);
        rd_chk(10'h020, 32'hA5A5_5A5A, "R2 grp word0");
        rd_chk(10'h021, 32'h1234_5678, "R2 grp word1");

        // R10 unimplemented words
        wr_reg(10'h022, 32'hFFFF_FFFF);
        rd_chk(10'h022, 0, "R10 grp word2");
        rd_chk(10'h020, 32'hA5A5_5A5A, "R10 neighbour kept");
        wr_reg(10'h110, 32'hFFFF_FFFF);
        rd_chk(10'h110, 0, "R10 prio word16");
        rd_chk(10'h100, 0, "R10 prio word0 kept");
        rd_chk(10'h05F, 0, "R10 en word31");
        rd_chk(10'h001, 0, "R10 gap");
        rd_chk(10'h3FF, 0, "R10 top");

        // R3 set-enable
        wr_reg(10'h041, 32'h0000_00F0);
        wr_reg(10'h041, 32'h0000_0F00);
        rd_chk(10'h041, 32'h0000_0FF0, "R3 accumulate");
        rd_chk(10'h061, 32'h0000_0FF0, "R3 via clear bank");
        wr_reg(10'h041, 32'h0);
        rd_chk(10'h041, 32'h0000_0FF0, "R3 zero write");

        // R4 clear-enable
        wr_reg(10'h061, 32'h0000_0030);
        rd_chk(10'h041, 32'h0000_0FC0, "R4 clear");
        wr_reg(10'h061, 32'h0);
        rd_chk(10'h061, 32'h0000_0FC0, "R4 zero write");

        // R5 priority sweep
        for (int w = 0; w < 16; w++)
            wr_reg(10'(32'h100 + w), {pv(4*w+3), pv(4*w+2), pv(4*w+1), pv(4*w)});
        for (int w = 0; w < 16; w++)
            rd_chk(10'(32'h100 + w), {pv(4*w+3), pv(4*w+2), pv(4*w+1), pv(4*w)}, "R5 prio");

        // R6 control
        wr_reg(10'h000, 32'hFFFF_FFFF);
        rd_chk(10'h000, 32'h0000_000B, "R6 ctrl bits");
        wr_reg(10'h000, 32'h0000_0004);
        rd_chk(10'h000, 0, "R6 ctrl unused");

        // Selection setup
        wr_reg(10'h020, 0);
        wr_reg(10'h021, 0);
        wr_reg(10'h041, 32'hFFFF_FFFF);
        wr_reg(10'h000, 32'h1);

        // R9 line k maps to number k+32
        for (int k = 0; k < NSPI; k++) begin
            periph = NSPI'(1) << k;
            out_chk(1, k + 32, 0, 1, "R9 single line");
        end
        periph = '0;
        wr_reg(10'h040, 32'hFFFF_FFFF);
        out_chk(0, 0, 0, 0, "R9 private numbers never pend");

        // R7 lowest value wins
        periph = '1;
        out_chk(1, 63, 0, 1, "R7 lowest value");
        periph = 32'h0000_FFFF;
        out_chk(1, 47, 0, 1, "R7 subset");
        for (int w = 8; w < 16; w++) wr_reg(10'(32'h100 + w), 32'h4040_4040);
        periph = '1;
        out_chk(1, 32, 0, 1, "R7 tie lowest id");
        periph = 32'hFFFF_0000;
        out_chk(1, 48, 0, 1, "R7 tie subset");
        wr_reg(10'h10A, 32'h4040_3F40);
        periph = '1;
        out_chk(1, 41, 0, 1, "R7 lane1 value");
        wr_reg(10'h10A, 32'h4040_4040);

        // R8 routing
        wr_reg(10'h000, 32'h9);
        out_chk(1, 32, 1, 0, "R8 group0 fast");
        wr_reg(10'h000, 32'h1);
        out_chk(1, 32, 0, 1, "R8 group0 normal");
        wr_reg(10'h021, 32'hFFFF_FFFF);
        wr_reg(10'h000, 32'hB);
        out_chk(1, 32, 0, 1, "R8 group1 normal");
        wr_reg(10'h000, 32'h9);
        out_chk(0, 0, 0, 0, "R8 group1 not forwarded");
        wr_reg(10'h021, 32'hAAAA_AAAA);
        wr_reg(10'h000, 32'hB);
        out_chk(1, 32, 1, 0, "R8 mixed group0 wins");
        wr_reg(10'h000, 32'hA);
        out_chk(1, 33, 0, 1, "R8 mixed group0 off");

        // R11 same-cycle line drop and clear-enable write
        wr_reg(10'h021, 0);
        wr_reg(10'h000, 32'hB);
        periph = 32'h3;
        out_chk(1, 32, 1, 0, "R11 before");
        @(negedge clk);
        addr = 10'h061; wdata = 32'h2; wr = 1'b1;
        periph = 32'h2;
        out_chk(1, 33, 1, 0, "R11 line drop same cycle");
        @(negedge clk);
        wr = 1'b0;
        out_chk(0, 0, 0, 0, "R11 write after edge");
        rd_chk(10'h041, 32'hFFFF_FFFD, "R4 combined clear");

        finish_run();
    end
endmodule